// File: doc/BRIEF.md
# Page-Walk Directory Region Cache

This block is a small, fully associative store that lives next to the leaf TLB of a multi-level page walker. Each entry remembers which physical page directory serves one 1 GiB slice of the virtual address space. When the leaf TLB misses, the walker presents the faulting virtual address. One cycle later it learns whether the slice is known. On a hit it receives the frame number of the page directory and starts the walk there, so it reads only the directory and the page table. The two upper table levels are skipped.

On a miss the walker does the full walk and then offers the directory frame it found back to the cache. The offer is accepted only when both upper levels were present. Whether the final leaf entry was present or had the right permissions plays no part, because the upper-level result is valid either way. A region that is already cached is refreshed in place. A new region takes a free slot if one exists, and otherwise replaces the least recently used entry. A single flush input empties the whole cache at once.

The slice key is the virtual address bits from bit 30 upward. For example, the addresses 0x0000_0000 through 0x3FFF_FFFF all share one entry.

Top module: `dir_region_cache`

## Requirements
- R1: After reset every entry is invalid, so the first lookup of any address misses.
- R2: A lookup request in one cycle produces `r_vld` high in the next cycle only. A cycle with no request produces `r_vld` low in the next cycle.
- R3: A lookup hits and returns the stored directory frame for any address whose bits [47:30] equal those of an installed address, whatever its bits [29:0] are.
- R4: A lookup whose bits [47:30] match no valid entry misses.
- R5: A fill offered with `fill_upper_ok` low creates no entry, and a later lookup of that region misses.
- R6: A fill for a region that is already cached overwrites that entry's frame without taking a second slot, so all other cached regions stay resident.
- R7: When all entries are valid, a fill of a new region evicts the entry that was least recently used. Both lookup hits and fills count as use.
- R8: `flush_all` invalidates every entry, and it wins over a fill presented in the same cycle.
- R9: A lookup answers from the contents as they stood before any fill or flush presented in the same cycle.
- R10: A miss response carries a directory frame of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_req | input | 1 | Lookup request strobe |
| q_va | input | 48 | Virtual address to look up |
| r_vld | output | 1 | Lookup response strobe, one cycle after `q_req` |
| r_hit | output | 1 | Region was found |
| r_dir_base | output | 40 | Physical frame number of the page directory on a hit, zero on a miss |
| fill_req | input | 1 | Fill offer strobe from the walker |
| fill_va | input | 48 | Virtual address whose walk produced the frame |
| fill_upper_ok | input | 1 | Both upper table levels were present |
| fill_dir_base | input | 40 | Directory frame number found by the walk |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench looks up addresses at both ends of a 1 GiB slice and just past it. A design that keyed on the wrong bits would hit the next slice or miss inside its own slice. It fills all four slots, touches the oldest one and then adds a fifth region. Only the untouched oldest region may vanish. A design that ignored lookup hits for recency, or that used FIFO order, evicts the wrong entry. Refilling a resident region must keep all four regions resident, which catches a design that allocates a duplicate slot. The bench also presents lookups in the same cycle as a fill or a flush, and a flush together with a fill. These cases expose designs that bypass new contents into the response or that let the fill survive the flush.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

    // Default geometry of the cache
    localparam int DIRC_ENTRIES    = 4;
    localparam int DIRC_VA_W       = 48;
    localparam int DIRC_PFN_W      = 40;
    localparam int DIRC_REGION_LSB = 30;

    // What a fill offer does to the array
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_REFRESH = 2'd1,
        ACT_FILL    = 2'd2,
        ACT_EVICT   = 2'd3
    } fill_act_e;

    // Registered lookup answer
    typedef struct packed {
        logic                  vld;
        logic                  hit;
        logic [DIRC_PFN_W-1:0] base;
    } dirc_rsp_t;

endpackage

// File: rtl/dirc_match.sv
module dirc_match #(
    parameter int N     = 4,
    parameter int TAG_W = 18,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [TAG_W-1:0] tags [N],
    input  logic [TAG_W-1:0] key,
    output logic [N-1:0]     hit_vec,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    // Compare the key against every slot in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    assign hit = |hit_vec;

    // Encode the matching slot; at most one slot matches a region
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dirc_lru.sv
module dirc_lru #(
    parameter int N = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             use_a,
    input  logic [IDX_W-1:0] idx_a,
    input  logic             use_b,
    input  logic [IDX_W-1:0] idx_b,
    output logic [IDX_W-1:0] oldest
);
    // Age per slot: 0 is most recent, N-1 is least recent; ages stay a permutation
    logic [IDX_W-1:0] age_q   [N];
    logic [IDX_W-1:0] age_mid [N];
    logic [IDX_W-1:0] age_d   [N];

    // Apply use A first (lookup hit), then use B (fill) on the result
    always_comb begin
        for (int i = 0; i < N; i++) begin
            age_mid[i] = age_q[i];
        end
        if (use_a) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == idx_a) begin
                    age_mid[i] = '0;
                end else if (age_q[i] < age_q[idx_a]) begin
                    age_mid[i] = age_q[i] + 1'b1;
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            age_d[i] = age_mid[i];
        end
        if (use_b) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == idx_b) begin
                    age_d[i] = '0;
                end else if (age_mid[i] < age_mid[idx_b]) begin
                    age_d[i] = age_mid[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                age_q[i] <= IDX_W'(i);
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                age_q[i] <= age_d[i];
            end
        end
    end

    always_comb begin
        oldest = '0;
        for (int i = 0; i < N; i++) begin
            if (age_q[i] == IDX_W'(N - 1)) begin
                oldest = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dir_region_cache.sv
module dir_region_cache
    import dirc_pkg::*;
#(
    parameter int ENTRIES    = DIRC_ENTRIES,
    parameter int VA_W       = DIRC_VA_W,
    parameter int PFN_W      = DIRC_PFN_W,
    parameter int REGION_LSB = DIRC_REGION_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_req,
    input  logic [VA_W-1:0]  q_va,
    output logic             r_vld,
    output logic             r_hit,
    output logic [PFN_W-1:0] r_dir_base,
    input  logic             fill_req,
    input  logic [VA_W-1:0]  fill_va,
    input  logic             fill_upper_ok,
    input  logic [PFN_W-1:0] fill_dir_base,
    input  logic             flush_all
);
    localparam int TAG_W = VA_W - REGION_LSB;
    localparam int IDX_W = $clog2(ENTRIES);

    // Entry storage
    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [PFN_W-1:0]   base_q [ENTRIES];

    logic [TAG_W-1:0] q_key;
    logic [TAG_W-1:0] f_key;
    assign q_key = q_va[VA_W-1:REGION_LSB];
    assign f_key = fill_va[VA_W-1:REGION_LSB];

    // Lookup match
    logic [ENTRIES-1:0] q_hit_vec;
    logic               q_hit;
    logic [IDX_W-1:0]   q_idx;

    dirc_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_q_match (
        .valid   (vld_q),
        .tags    (tag_q),
        .key     (q_key),
        .hit_vec (q_hit_vec),
        .hit     (q_hit),
        .hit_idx (q_idx)
    );

    // Fill match, used to refresh a resident region in place
    logic [ENTRIES-1:0] f_hit_vec;
    logic               f_hit;
    logic [IDX_W-1:0]   f_idx;

    dirc_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_f_match (
        .valid   (vld_q),
        .tags    (tag_q),
        .key     (f_key),
        .hit_vec (f_hit_vec),
        .hit     (f_hit),
        .hit_idx (f_idx)
    );

    // Lowest free slot
    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Recency tracking
    logic             q_use;
    logic             f_use;
    logic [IDX_W-1:0] oldest;
    logic [IDX_W-1:0] tgt;
    fill_act_e        act;

    assign q_use = q_req && q_hit;
    assign f_use = (act != ACT_IDLE);

    dirc_lru #(.N(ENTRIES)) u_lru (
        .clk    (clk),
        .rst    (rst),
        .use_a  (q_use),
        .idx_a  (q_idx),
        .use_b  (f_use),
        .idx_b  (tgt),
        .oldest (oldest)
    );

    // Decide what a fill does: refresh, take a free slot, or evict
    always_comb begin
        act = ACT_IDLE;
        tgt = '0;
        if (fill_req && fill_upper_ok && !flush_all) begin
            if (f_hit) begin
                act = ACT_REFRESH;
                tgt = f_idx;
            end else if (free_any) begin
                act = ACT_FILL;
                tgt = free_idx;
            end else begin
                act = ACT_EVICT;
                tgt = oldest;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_all) begin
            vld_q <= '0;
        end else if (act != ACT_IDLE) begin
            vld_q[tgt]  <= 1'b1;
            tag_q[tgt]  <= f_key;
            base_q[tgt] <= fill_dir_base;
        end
    end

    // Response from pre-update contents
    dirc_rsp_t rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.vld  <= q_req;
            rsp_q.hit  <= q_use;
            rsp_q.base <= q_use ? base_q[q_idx] : '0;
        end
    end

    assign r_vld      = rsp_q.vld;
    assign r_hit      = rsp_q.hit;
    assign r_dir_base = rsp_q.base;
endmodule

// File: rtl/dirc_checker.sv
module dirc_checker #(
    parameter int N     = 4,
    parameter int PFN_W = 40
) (
    input logic             clk,
    input logic             rst,
    input logic             q_req,
    input logic             r_vld,
    input logic             r_hit,
    input logic [PFN_W-1:0] r_dir_base,
    input logic             fill_req,
    input logic             fill_upper_ok,
    input logic             flush_all,
    input logic [N-1:0]     vld_q,
    input logic [N-1:0]     q_hit_vec,
    input logic [N-1:0]     f_hit_vec
);
    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (vld_q == '0)); // R1

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        q_req |=> r_vld); // R2

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        !q_req |=> !r_vld); // R2

    AST_UPPER_GATE: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_upper_ok && !flush_all) |=> $stable(vld_q)); // R5

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_hit_vec) && $onehot0(f_hit_vec)); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (vld_q == '0)); // R8

    AST_FLUSH_THEN_MISS: assert property (@(posedge clk) disable iff (rst)
        flush_all ##1 q_req |=> !r_hit); // R8

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (r_vld && !r_hit) |-> (r_dir_base == '0)); // R10
endmodule

bind dir_region_cache dirc_checker #(.N(ENTRIES), .PFN_W(PFN_W)) u_dirc_checker (
    .clk           (clk),
    .rst           (rst),
    .q_req         (q_req),
    .r_vld         (r_vld),
    .r_hit         (r_hit),
    .r_dir_base    (r_dir_base),
    .fill_req      (fill_req),
    .fill_upper_ok (fill_upper_ok),
    .flush_all     (flush_all),
    .vld_q         (vld_q),
    .q_hit_vec     (q_hit_vec),
    .f_hit_vec     (f_hit_vec)
);

// File: tb/tb_dir_region_cache.sv
module tb_dir_region_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        q_req = 1'b0;
    logic [47:0] q_va = '0;
    logic        r_vld;
    logic        r_hit;
    logic [39:0] r_dir_base;
    logic        fill_req = 1'b0;
    logic [47:0] fill_va = '0;
    logic        fill_upper_ok = 1'b0;
    logic [39:0] fill_dir_base = '0;
    logic        flush_all = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dir_region_cache dut (
        .clk           (clk),
        .rst           (rst),
        .q_req         (q_req),
        .q_va          (q_va),
        .r_vld         (r_vld),
        .r_hit         (r_hit),
        .r_dir_base    (r_dir_base),
        .fill_req      (fill_req),
        .fill_va       (fill_va),
        .fill_upper_ok (fill_upper_ok),
        .fill_dir_base (fill_dir_base),
        .flush_all     (flush_all)
    );

    function automatic logic [47:0] va_at(input logic [17:0] region, input logic [29:0] off);
        return {region, off};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Lookup one address; checks strobe, hit and base
    task automatic probe(input string req, input logic [47:0] va,
                         input logic exp_hit, input logic [39:0] exp_base);
        @(negedge clk);
        q_req = 1'b1;
        q_va  = va;
        @(negedge clk);
        q_req = 1'b0;
        check({req, " vld"}, {63'd0, r_vld}, 64'd1);
        check({req, " hit"}, {63'd0, r_hit}, {63'd0, exp_hit});
        check({req, " base"}, {24'd0, r_dir_base}, {24'd0, exp_base});
    endtask

    task automatic fill(input logic [47:0] va, input logic [39:0] base, input logic ok);
        @(negedge clk);
        fill_req      = 1'b1;
        fill_va       = va;
        fill_dir_base = base;
        fill_upper_ok = ok;
        @(negedge clk);
        fill_req      = 1'b0;
        fill_upper_ok = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R2 idle no strobe", {63'd0, r_vld}, 64'd0);
        probe("R1 empty after reset", va_at(18'h0, 30'h0), 1'b0, 40'h0);
        probe("R10 miss base zero", va_at(18'h3, 30'h5), 1'b0, 40'h0);
        @(negedge clk);
        check("R2 single-cycle strobe", {63'd0, r_vld}, 64'd0);
    endtask

    task automatic t_region_span();
        do_reset();
        fill(va_at(18'h0, 30'h0), 40'hA_1000, 1'b1);
        probe("R3 region low end", 48'h0000_0000_0000, 1'b1, 40'hA_1000);
        probe("R3 region high end", 48'h0000_3FFF_FFFF, 1'b1, 40'hA_1000);
        probe("R3 mid region", 48'h0000_2233_4455, 1'b1, 40'hA_1000);
        probe("R4 next region", 48'h0000_4000_0000, 1'b0, 40'h0);
        probe("R4 high tag bit", 48'h8000_0000_0000, 1'b0, 40'h0);
    endtask

    task automatic t_upper_gate();
        do_reset();
        fill(va_at(18'h7, 30'h0), 40'hB_0000, 1'b0);
        probe("R5 rejected fill", va_at(18'h7, 30'h123), 1'b0, 40'h0);
        fill(va_at(18'h7, 30'h0), 40'hB_0001, 1'b1);
        probe("R5 accepted fill", va_at(18'h7, 30'h0), 1'b1, 40'hB_0001);
    endtask

    task automatic t_refresh();
        do_reset();
        for (int i = 0; i < 4; i++) fill(va_at(18'(i + 1), 30'h0), 40'(32'h100 + i), 1'b1);
        fill(va_at(18'h2, 30'h9), 40'hC_CCCC, 1'b1);
        probe("R6 refreshed base", va_at(18'h2, 30'h0), 1'b1, 40'hC_CCCC);
        probe("R6 keeps region 1", va_at(18'h1, 30'h0), 1'b1, 40'h100);
        probe("R6 keeps region 3", va_at(18'h3, 30'h0), 1'b1, 40'h102);
        probe("R6 keeps region 4", va_at(18'h4, 30'h0), 1'b1, 40'h103);
    endtask

    task automatic t_lru();
        do_reset();
        // Fill order A,B,C,D makes A oldest; a hit on A leaves B oldest
        for (int i = 0; i < 4; i++) fill(va_at(18'(16 + i), 30'h0), 40'(32'h200 + i), 1'b1);
        probe("R7 touch A", va_at(18'd16, 30'h0), 1'b1, 40'h200);
        fill(va_at(18'd20, 30'h0), 40'h204, 1'b1);
        probe("R7 B evicted", va_at(18'd17, 30'h0), 1'b0, 40'h0);
        probe("R7 A kept", va_at(18'd16, 30'h0), 1'b1, 40'h200);
        probe("R7 C kept", va_at(18'd18, 30'h0), 1'b1, 40'h202);
        probe("R7 D kept", va_at(18'd19, 30'h0), 1'b1, 40'h203);
        probe("R7 E present", va_at(18'd20, 30'h0), 1'b1, 40'h204);
        // Recency now A,C,D,E oldest to newest; fill F evicts A
        fill(va_at(18'd21, 30'h0), 40'h205, 1'b1);
        probe("R7 A evicted next", va_at(18'd16, 30'h0), 1'b0, 40'h0);
        probe("R7 C survives", va_at(18'd18, 30'h0), 1'b1, 40'h202);
    endtask

    task automatic t_same_cycle();
        do_reset();
        @(negedge clk);
        q_req = 1'b1; q_va = va_at(18'h9, 30'h0);
        fill_req = 1'b1; fill_va = va_at(18'h9, 30'h0);
        fill_dir_base = 40'hD_0000; fill_upper_ok = 1'b1;
        @(negedge clk);
        q_req = 1'b0; fill_req = 1'b0; fill_upper_ok = 1'b0;
        check("R9 lookup with fill misses", {63'd0, r_hit}, 64'd0);
        probe("R9 fill visible after", va_at(18'h9, 30'h0), 1'b1, 40'hD_0000);
        @(negedge clk);
        q_req = 1'b1; q_va = va_at(18'h9, 30'h4); flush_all = 1'b1;
        @(negedge clk);
        q_req = 1'b0; flush_all = 1'b0;
        check("R9 lookup with flush hits", {63'd0, r_hit}, 64'd1);
        check("R9 lookup with flush base", {24'd0, r_dir_base}, 64'hD_0000);
    endtask

    task automatic t_flush();
        do_reset();
        for (int i = 0; i < 4; i++) fill(va_at(18'(40 + i), 30'h0), 40'(32'h300 + i), 1'b1);
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        for (int i = 0; i < 4; i++) probe("R8 flushed", va_at(18'(40 + i), 30'h0), 1'b0, 40'h0);
        @(negedge clk);
        flush_all = 1'b1; fill_req = 1'b1; fill_va = va_at(18'd50, 30'h0);
        fill_dir_base = 40'hE_0000; fill_upper_ok = 1'b1;
        @(negedge clk);
        flush_all = 1'b0; fill_req = 1'b0; fill_upper_ok = 1'b0;
        probe("R8 flush beats fill", va_at(18'd50, 30'h0), 1'b0, 40'h0);
    endtask

    initial begin
        t_reset();
        t_region_span();
        t_upper_gate();
        t_refresh();
        t_lru();
        t_same_cycle();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule